// File: doc/BRIEF.md
# MDIO Clause-22 Management Master

This block lets software reach the management registers of an Ethernet PHY over the two-wire clause 22 management bus. Software sets a clock divisor and a data hold time in a speed register. It then writes one 32-bit command word that holds the start code, opcode, PHY address, register address, turnaround pattern and (for writes) the data. That single write launches the transfer. The block always sends a 32-bit preamble of ones, then the command word MSB-first. It drives MDC and the tri-state controls of the MDIO line.

On a read, the block lets go of MDIO from the turnaround onward. It samples the PHY's 16 data bits on rising MDC edges and writes them into the low half of the command word. At the end of any frame it sets a sticky completion flag, which software clears by writing a one to it. A busy bit can be read while a command is pending or in flight. If the divisor is zero, MDC stays idle and any command waits until a nonzero divisor is programmed.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low, and the command word (address 0), speed register (address 1) and event register (address 2) all read as zero.
- R2: Writing address 0 while idle, with a nonzero divisor, sends a 64-bit frame on the rising MDC edges: 32 ones, then the command word bits 31 down to 0. The command word fields are start [31:30], opcode [29:28] (10 read, 01 write), PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0]. The output enable is high for every bit of a frame whose opcode is not 10.
- R3: The divisor is held in speed register bits [6:1] and the hold time in bits [10:8]. All other bits read as zero. MDC is high for divisor clocks and low for divisor clocks, so the rising-edge spacing is twice the divisor.
- R4: MDIO changes hold+1 system clocks after a rising MDC edge. When hold+1 exceeds the divisor, the change happens at the falling MDC edge (divisor clocks after the rise).
- R5: For opcode 10, the output enable is low from bit 46 of the frame (the first turnaround bit) to the end. The 16 data bits are sampled on rising MDC edges, MSB first, and replace command word bits [15:0]. Bits [31:16] are kept.
- R6: Event register bit 0 sets when a frame ends and stays set. Writing 1 to it clears it, and writing 0 leaves it unchanged. Bit 1 reads 1 while a command is pending or running and 0 otherwise.
- R7: A write to address 0 while busy is ignored: the command word and the frame in flight are unchanged.
- R8: With a divisor of zero, a command write produces no MDC edges and stays pending (busy=1). Once a nonzero divisor is written, the frame is sent.
- R9: While not busy, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 drives the line) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The bench goes after the hold timing at its limits: a hold time that fits within the high phase, and a hold time larger than the divisor. A design that ignores the clamp would change MDIO after the falling edge, into the next bit's setup window. It checks that a read releases the line at the first turnaround bit and not at the data bits; a late release would make the master fight the PHY's turnaround drive. It also checks that a command written with a zero divisor waits rather than being dropped or sent with a stalled clock, and that a command write during a frame corrupts neither the word nor the bits on the wire. Finally, it checks that a completion flag cleared by writing zero stays set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int CMD_W      = 32;
    localparam int DATA_W     = 16;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = PRE_LEN + CMD_W;
    localparam int FIDX_W     = $clog2(FRAME_LEN);

    localparam int SPD_DIV_W  = 6;
    localparam int SPD_HOLD_W = 3;
    localparam int DIV_LSB    = 1;
    localparam int HOLD_LSB   = 8;

    localparam logic [ADDR_W-1:0] A_CMD   = 2'd0;
    localparam logic [ADDR_W-1:0] A_SPEED = 2'd1;
    localparam logic [ADDR_W-1:0] A_EVENT = 2'd2;

    // frame positions that change line direction or sampling
    localparam logic [FIDX_W-1:0] TA_POS   = FIDX_W'(PRE_LEN + CMD_W - DATA_W - 2);
    localparam logic [FIDX_W-1:0] DATA_POS = FIDX_W'(PRE_LEN + CMD_W - DATA_W);
    localparam logic [FIDX_W-1:0] LAST_POS = FIDX_W'(FRAME_LEN - 1);

    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic [1:0]        st;
        logic [1:0]        op;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [1:0]        ta;
        logic [DATA_W-1:0] data;
    } mgmt_cmd_t;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_WAIT,
        CTL_RUN
    } ctl_state_e;

    // bit number idx of the frame, counted from the first preamble bit
    function automatic logic frame_bit(input mgmt_cmd_t c, input logic [FIDX_W-1:0] idx);
        logic [FRAME_LEN-1:0] f;
        f = {{PRE_LEN{1'b1}}, c};
        return f[FRAME_LEN - 1 - int'(idx)];
    endfunction

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W  = SPD_DIV_W,
    parameter int HOLD_W = SPD_HOLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              done,
    input  logic              is_read,
    input  logic [DATA_W-1:0] rdata,
    output logic              start,
    output mgmt_cmd_t         cmd,
    output logic [DIV_W-1:0]  div,
    output logic [HOLD_W-1:0] hold,
    output logic              busy,
    output logic              evt
);

    ctl_state_e state;
    logic cmd_wr, spd_wr, evt_wr;
    logic [REG_W-1:0] spd_view;

    assign cmd_wr = wr_en && (wr_addr == A_CMD);
    assign spd_wr = wr_en && (wr_addr == A_SPEED);
    assign evt_wr = wr_en && (wr_addr == A_EVENT);

    assign busy  = (state != CTL_IDLE);
    assign start = (state == CTL_WAIT) && (div != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CTL_IDLE;
            cmd   <= '0;
            div   <= '0;
            hold  <= '0;
            evt   <= 1'b0;
        end else begin
            unique case (state)
                CTL_IDLE: begin
                    if (cmd_wr) begin
                        cmd   <= mgmt_cmd_t'(wr_data);
                        state <= CTL_WAIT;
                    end
                end
                CTL_WAIT: begin
                    if (div != '0) state <= CTL_RUN;
                end
                CTL_RUN: begin
                    if (done) begin
                        state <= CTL_IDLE;
                        if (is_read) cmd.data <= rdata;
                    end
                end
                default: state <= CTL_IDLE;
            endcase
            if (spd_wr) begin
                div  <= wr_data[DIV_LSB +: DIV_W];
                hold <= wr_data[HOLD_LSB +: HOLD_W];
            end
            if (evt_wr && wr_data[0]) evt <= 1'b0;
            if (done) evt <= 1'b1;
        end
    end

    always_comb begin
        spd_view = '0;
        spd_view[DIV_LSB +: DIV_W]   = div;
        spd_view[HOLD_LSB +: HOLD_W] = hold;
    end

    always_comb begin
        unique case (rd_addr)
            A_CMD:   rd_data = cmd;
            A_SPEED: rd_data = spd_view;
            A_EVENT: rd_data = {{(REG_W-2){1'b0}}, busy, evt};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mdio_tick.sv
module mdio_tick
    import mdio_pkg::*;
#(
    parameter int DIV_W  = SPD_DIV_W,
    parameter int HOLD_W = SPD_HOLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [HOLD_W-1:0] hold_in,
    output logic              mdc,
    output logic              edge_stb,
    output logic              hold_stb
);

    localparam int CNT_W = DIV_W + 1;

    logic              run;
    logic [CNT_W-1:0]  bcnt;
    logic [DIV_W-1:0]  div_q;
    logic [HOLD_W-1:0] hold_q;
    logic [CNT_W-1:0]  last_cnt, nxt, div_ext, hold_p1, hold_eff;
    logic              wrap;

    assign div_ext  = CNT_W'(div_q);
    assign last_cnt = {div_q, 1'b0} - CNT_W'(1);
    assign nxt      = bcnt + CNT_W'(1);
    assign hold_p1  = CNT_W'(hold_q) + CNT_W'(1);
    assign hold_eff = (hold_p1 > div_ext) ? div_ext : hold_p1;

    // wrap cycle: the next edge raises MDC (unless the frame stops)
    assign wrap     = run && (bcnt == last_cnt);
    assign edge_stb = wrap;
    assign hold_stb = run && !wrap && (nxt == hold_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            bcnt   <= '0;
            div_q  <= '0;
            hold_q <= '0;
            mdc    <= 1'b0;
        end else if (start) begin
            run    <= 1'b1;
            div_q  <= div_in;
            hold_q <= hold_in;
            bcnt   <= CNT_W'(div_in);
            mdc    <= 1'b0;
        end else if (run) begin
            if (stop) begin
                run  <= 1'b0;
                bcnt <= '0;
                mdc  <= 1'b0;
            end else if (wrap) begin
                bcnt <= '0;
                mdc  <= 1'b1;
            end else begin
                bcnt <= nxt;
                if (nxt == div_ext) mdc <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mgmt_cmd_t         cmd,
    input  logic              edge_stb,
    input  logic              hold_stb,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              stop,
    output logic              done,
    output logic              active,
    output logic              is_read,
    output logic [FIDX_W-1:0] bit_idx,
    output logic [DATA_W-1:0] rdata
);

    logic              last;
    logic [FIDX_W-1:0] nidx;

    assign is_read = (cmd.op == OP_READ);
    assign nidx    = bit_idx + FIDX_W'(1);
    assign stop    = active && edge_stb && last;
    assign done    = stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            last    <= 1'b0;
            bit_idx <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            rdata   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            last    <= 1'b0;
            bit_idx <= '0;
            mdio_o  <= frame_bit(cmd, '0);
            mdio_oe <= 1'b1;
            rdata   <= '0;
        end else if (active) begin
            if (edge_stb) begin
                if (last) begin
                    active  <= 1'b0;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b0;
                end else begin
                    if (is_read && (bit_idx >= DATA_POS))
                        rdata <= {rdata[DATA_W-2:0], mdio_i};
                    if (bit_idx == LAST_POS) last <= 1'b1;
                end
            end else if (hold_stb && !last) begin
                bit_idx <= nidx;
                mdio_o  <= frame_bit(cmd, nidx);
                mdio_oe <= !(is_read && (nidx >= TA_POS));
            end
        end
    end

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_pkg::*;
#(
    parameter int DIV_W  = SPD_DIV_W,
    parameter int HOLD_W = SPD_HOLD_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    mgmt_cmd_t         cmd;
    logic              start, stop, done, busy, evt;
    logic              frame_active, is_read;
    logic              edge_stb, hold_stb;
    logic [DIV_W-1:0]  div;
    logic [HOLD_W-1:0] hold;
    logic [DATA_W-1:0] rdata;
    logic [FIDX_W-1:0] bit_idx;

    mdio_regs #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .done    (done),
        .is_read (is_read),
        .rdata   (rdata),
        .start   (start),
        .cmd     (cmd),
        .div     (div),
        .hold    (hold),
        .busy    (busy),
        .evt     (evt)
    );

    mdio_tick #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .div_in   (div),
        .hold_in  (hold),
        .mdc      (mdc),
        .edge_stb (edge_stb),
        .hold_stb (hold_stb)
    );

    mdio_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (cmd),
        .edge_stb (edge_stb),
        .hold_stb (hold_stb),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .stop     (stop),
        .done     (done),
        .active   (frame_active),
        .is_read  (is_read),
        .bit_idx  (bit_idx),
        .rdata    (rdata)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        frame_active,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        done,
    input logic        evt,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [31:0] cmd_word,
    input logic        is_read,
    input logic [5:0]  bit_idx
);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    p_pending_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_active) |-> (!mdc && !mdio_oe));

    p_done_flags_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (evt && !busy));

    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2 && wr_data[0] && !done) |=> !evt);

    p_busy_cmd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && wr_en && wr_addr == 2'd0) |=> (cmd_word == $past(cmd_word)));

    p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_active && is_read && bit_idx >= 6'd48) |-> !mdio_oe);

endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .frame_active (frame_active),
    .mdc          (mdc),
    .mdio_oe      (mdio_oe),
    .done         (done),
    .evt          (evt),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .cmd_word     (cmd),
    .is_read      (is_read),
    .bit_idx      (bit_idx)
);

// File: tb/test_mdio_mgmt.sv
module test_mdio_mgmt;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt i_mdio_mgmt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // line monitor and PHY model
    logic        stat_clr = 1'b0;
    logic [15:0] phy_data = 16'h0000;
    logic [63:0] cap, oe_cap;
    int rises, last_rise, cyc, pmin, pmax, hmin, hmax;
    logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

    initial begin
        cyc = 0; rises = 0; last_rise = 0;
        pmin = 1000; pmax = 0; hmin = 1000; hmax = 0;
        cap = '0; oe_cap = '0;
    end

    always @(negedge clk) begin
        cyc++;
        if (stat_clr) begin
            rises = 0; pmin = 1000; pmax = 0; hmin = 1000; hmax = 0;
            cap = '0; oe_cap = '0;
        end else begin
            if (mdio_oe && prev_oe && (mdio_o !== prev_o) && rises > 0) begin
                if (cyc - last_rise < hmin) hmin = cyc - last_rise;
                if (cyc - last_rise > hmax) hmax = cyc - last_rise;
            end
            if (mdc && !prev_mdc) begin
                if (rises > 0) begin
                    if (cyc - last_rise < pmin) pmin = cyc - last_rise;
                    if (cyc - last_rise > pmax) pmax = cyc - last_rise;
                end
                if (rises < 64) begin
                    cap[63-rises]    = mdio_o;
                    oe_cap[63-rises] = mdio_oe;
                end
                last_rise = cyc;
                rises++;
                mdio_i = (rises >= 48 && rises < 64) ? phy_data[63-rises] : 1'b1;
            end
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] spd(input int dv, input int hd);
        return (32'(hd) << 8) | (32'(dv) << 1);
    endfunction

    task automatic clear_stats();
        @(posedge clk); stat_clr = 1'b1;
        @(posedge clk); stat_clr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        int n = 0;
        do begin
            reg_read(2'd2, d);
            n++;
        end while (d[1] && n < 20000);
    endtask

    task automatic run_frame(input logic [31:0] c);
        clear_stats();
        reg_write(2'd0, c);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1", "mdc", 64'(mdc), 64'd0);
        check("R1", "mdio_oe", 64'(mdio_oe), 64'd0);
        reg_read(2'd0, d); check("R1", "cmd", 64'(d), 64'd0);
        reg_read(2'd1, d); check("R1", "speed", 64'(d), 64'd0);
        reg_read(2'd2, d); check("R1", "event", 64'(d), 64'd0);
    endtask

    task automatic t_write_frame();
        logic [31:0] w, d;
        w = {2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'h5A3C};
        reg_write(2'd1, spd(4, 2));
        run_frame(w);
        check("R2", "rise count", 64'(rises), 64'd64);
        check("R2", "frame bits", cap, {32'hFFFF_FFFF, w});
        check("R2", "oe per bit", oe_cap, {64{1'b1}});
        check("R3", "period min", 64'(pmin), 64'd8);
        check("R3", "period max", 64'(pmax), 64'd8);
        check("R4", "hold min", 64'(hmin), 64'd3);
        check("R4", "hold max", 64'(hmax), 64'd3);
        reg_read(2'd2, d); check("R6", "event after write", 64'(d), 64'd1);
        check("R9", "idle mdc", 64'(mdc), 64'd0);
        check("R9", "idle oe", 64'(mdio_oe), 64'd0);
    endtask

    task automatic t_read_frame();
        logic [31:0] r, d;
        logic [63:0] exp;
        r = {2'b01, 2'b10, 5'h11, 5'h03, 2'b11, 16'h1234};
        exp = {32'hFFFF_FFFF, r};
        phy_data = 16'hA5C3;
        reg_write(2'd1, spd(3, 1));
        run_frame(r);
        check("R5", "rise count", 64'(rises), 64'd64);
        check("R5", "header bits", 64'(cap[63:18]), 64'(exp[63:18]));
        check("R5", "oe release", oe_cap, {{46{1'b1}}, {18{1'b0}}});
        reg_read(2'd0, d);
        check("R5", "read data in cmd", 64'(d), 64'({r[31:16], 16'hA5C3}));
    endtask

    task automatic t_event_w1c();
        logic [31:0] d;
        reg_write(2'd2, 32'h0);
        reg_read(2'd2, d); check("R6", "write 0 keeps flag", 64'(d), 64'd1);
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, d); check("R6", "write 1 clears flag", 64'(d), 64'd0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] w, d;
        w = 32'h5A3C_96E1;
        reg_write(2'd1, spd(4, 0));
        clear_stats();
        reg_write(2'd0, w);
        repeat (20) @(posedge clk);
        reg_read(2'd2, d); check("R6", "busy bit in flight", 64'(d[1]), 64'd1);
        reg_write(2'd0, 32'hDEAD_BEEF);
        reg_read(2'd0, d); check("R7", "cmd during frame", 64'(d), 64'(w));
        wait_idle();
        check("R7", "frame unchanged", cap, {32'hFFFF_FFFF, w});
        reg_read(2'd0, d); check("R7", "cmd after frame", 64'(d), 64'(w));
        reg_write(2'd2, 32'h1);
    endtask

    task automatic t_pending();
        logic [31:0] w, d;
        w = {2'b01, 2'b01, 5'h07, 5'h1F, 2'b10, 16'hC3A5};
        reg_write(2'd1, spd(0, 0));
        clear_stats();
        reg_write(2'd0, w);
        repeat (100) @(posedge clk);
        check("R8", "no mdc edges", 64'(rises), 64'd0);
        reg_read(2'd2, d); check("R8", "pending busy", 64'(d), 64'd2);
        reg_write(2'd1, spd(2, 0));
        wait_idle();
        check("R8", "frame sent later", cap, {32'hFFFF_FFFF, w});
        check("R3", "period div2", 64'(pmax), 64'd4);
        check("R4", "hold zero", 64'(hmax), 64'd1);
    endtask

    task automatic t_hold_clamp();
        logic [31:0] w;
        w = {2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'hA55A};
        reg_write(2'd1, spd(2, 7));
        run_frame(w);
        check("R4", "clamped hold min", 64'(hmin), 64'd2);
        check("R4", "clamped hold max", 64'(hmax), 64'd2);
        check("R2", "frame under clamp", cap, {32'hFFFF_FFFF, w});
        reg_write(2'd1, spd(1, 0));
        run_frame(w);
        check("R3", "period div1", 64'(pmax), 64'd2);
        check("R4", "hold div1", 64'(hmax), 64'd1);
        check("R2", "frame div1", cap, {32'hFFFF_FFFF, w});
    endtask

    task automatic t_speed_fields();
        logic [31:0] d;
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, d); check("R3", "speed readback", 64'(d), 64'h77E);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_write_frame();
        t_read_frame();
        t_event_w1c();
        t_busy_ignore();
        t_pending();
        t_hold_clamp();
        t_speed_fields();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail + 1);
        $finish;
    end

endmodule